// File: doc/BRIEF.md
# Scale-Space Extremum Keypoint Detector

This block takes three co-registered difference-of-Gaussian pixel streams, one each for a lower, middle and upper scale, and finds pixels of the middle scale that stand out from their whole 3×3×3 neighbourhood. The three streams arrive in raster order and share one valid strobe. Each stream runs through its own two-line delay. The taps of that delay feed a 3×3 register window, so that every accepted sample completes a full cube around the pixel one row and one column behind it.

A centre that is a strict extremum is screened twice more. It must have enough contrast, and its local curvature must not look like an edge: the Hessian test is built from the middle-scale window. A centre that survives every test is packed into a 24-bit record and offered on a FIFO write port. When the FIFO is full, the record is lost and a sticky flag is raised.

Top module: `kp_detect`

## Requirements
- R1: Row taps come from a 2·IMG_W-sample delay per scale with taps at IMG_W and 2·IMG_W. The sample at column x, row y completes the neighbourhood of centre (x-1, y-1), and that centre's record is offered with `fifo_wr_en` high in the cycle two clocks after the sample is accepted.
- R2: A centre is a candidate when its middle-scale value is strictly greater than all 26 neighbours in the three scales.
- R3: A centre is also a candidate when its value is strictly smaller than all 26 neighbours.
- R4: A neighbour equal to the centre disqualifies it, in any of the three scales.
- R5: A candidate whose absolute value is below CONTRAST_MIN is dropped. A value equal to CONTRAST_MIN passes.
- R6: The edge test uses the middle-scale window, with Dxx = L+R-2C, Dyy = U+D-2C and Dxy = (UL+DR-UR-DL)/4. A candidate is dropped when the determinant DxxDyy-Dxy² is not positive, or when (Dxx+Dyy)²·EDGE_RATIO ≥ (EDGE_RATIO+1)²·det.
- R7: Centres in the first or last column, or in the first or last row, of the IMG_W×IMG_H frame are never reported.
- R8: The record holds x in [23:15], y in [14:7], and the `in_scale` value sampled with the completing sample in [6:4]. Bits [3:0] hold |value| >> MAG_SHIFT, saturated at 15.
- R9: When `fifo_full` is high in the cycle a record is offered, the record is dropped and `overflow` goes high. It then stays high until reset.
- R10: Reset clears the raster position to (0,0), removes any pending record and clears `overflow`.
- R11: The raster position advances only on cycles where `in_valid` is high. Idle cycles between samples change neither the positions nor the records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | All three DoG samples are valid |
| in_dog_lo | input | DOG_W | Lower-scale DoG sample, signed |
| in_dog_mid | input | DOG_W | Middle-scale DoG sample, signed |
| in_dog_hi | input | DOG_W | Upper-scale DoG sample, signed |
| in_scale | input | 3 | Scale index placed into the record |
| fifo_full | input | 1 | Output FIFO cannot accept a word |
| fifo_wr_en | output | 1 | Write strobe for the output FIFO |
| fifo_wr_data | output | 24 | Packed keypoint record |
| overflow | output | 1 | Sticky flag: a record was dropped |

## Verification
Several properties are checked on every cycle. Records never carry a border coordinate. The record's scale field matches the index given two cycles earlier, and every write follows an accepted sample by two cycles. Overflow only rises while the FIFO is full and never falls outside reset. The bench scenarios show what the per-cycle checks cannot: whether a whole frame yields exactly the expected set of keypoints. These scenarios cover a strict maximum, a strict minimum, ties across scales, the contrast boundary, rejection of a ridge as an edge, saturation of the magnitude field and correct positions when the valid strobe has idle cycles.

// File: rtl/kp_pkg.sv
package kp_pkg;

    localparam int X_BITS   = 9;
    localparam int Y_BITS   = 8;
    localparam int SC_BITS  = 3;
    localparam int MAG_BITS = 4;
    localparam int REC_BITS = X_BITS + Y_BITS + SC_BITS + MAG_BITS;

    typedef struct packed {
        logic [X_BITS-1:0]   x;
        logic [Y_BITS-1:0]   y;
        logic [SC_BITS-1:0]  scale;
        logic [MAG_BITS-1:0] mag;
    } kp_rec_t;

    typedef enum logic [1:0] {
        EXT_NONE = 2'd0,
        EXT_MAX  = 2'd1,
        EXT_MIN  = 2'd2
    } ext_kind_t;

    function automatic logic [MAG_BITS-1:0] clip_mag(input logic [31:0] v);
        return (v > 32'd15) ? 4'hF : v[MAG_BITS-1:0];
    endfunction

endpackage

// File: rtl/kp_scale_window.sv
module kp_scale_window #(
    parameter int IMG_W = 320,
    parameter int DOG_W = 12
) (
    input  logic                   clk,
    input  logic                   en,
    input  logic signed [DOG_W-1:0] din,
    output logic [9*DOG_W-1:0]     win_flat
);
    localparam int DEPTH = 2 * IMG_W;

    logic signed [DOG_W-1:0] dly [DEPTH];
    logic signed [DOG_W-1:0] row_tap [3];
    logic signed [DOG_W-1:0] w [3][3];

    // row 0 = newest line, row 2 = oldest line
    assign row_tap[0] = din;
    assign row_tap[1] = dly[IMG_W-1];
    assign row_tap[2] = dly[DEPTH-1];

    always_ff @(posedge clk) begin
        if (en) begin
            dly[0] <= din;
            for (int i = 1; i < DEPTH; i++) dly[i] <= dly[i-1];
        end
    end

    // column 0 = newest column
    always_ff @(posedge clk) begin
        if (en) begin
            for (int r = 0; r < 3; r++) begin
                w[r][0] <= row_tap[r];
                w[r][1] <= w[r][0];
                w[r][2] <= w[r][1];
            end
        end
    end

    for (genvar r = 0; r < 3; r++) begin : g_row
        for (genvar c = 0; c < 3; c++) begin : g_col
            assign win_flat[(r*3+c)*DOG_W +: DOG_W] = w[r][c];
        end
    end

endmodule

// File: rtl/kp_screen.sv
module kp_screen
    import kp_pkg::*;
#(
    parameter int DOG_W        = 12,
    parameter int CONTRAST_MIN = 8,
    parameter int EDGE_RATIO   = 10,
    parameter int MAG_SHIFT    = 7
) (
    input  logic [27*DOG_W-1:0]  cube,
    output logic                 keep,
    output logic [MAG_BITS-1:0]  mag
);
    localparam int EW = 2 * DOG_W + 24;
    localparam int CTR = 13;
    localparam logic signed [EW-1:0] K2   = EW'(2);
    localparam logic signed [EW-1:0] K16  = EW'(16);
    localparam logic signed [EW-1:0] KR   = EW'(EDGE_RATIO);
    localparam logic signed [EW-1:0] KR1  = EW'((EDGE_RATIO + 1) * (EDGE_RATIO + 1));
    localparam logic [DOG_W-1:0]     TH   = DOG_W'(CONTRAST_MIN);

    logic signed [DOG_W-1:0] v [27];
    ext_kind_t               kind;
    logic                    is_max, is_min;
    logic [DOG_W-1:0]        abs_v, shifted;
    logic signed [EW-1:0]    dxx, dyy, hxy, tr, det16, lhs, rhs;
    logic                    contrast_ok, edge_ok;

    // index = scale*9 + row*3 + col; middle scale is scale 1
    always_comb begin
        for (int i = 0; i < 27; i++) v[i] = signed'(cube[i*DOG_W +: DOG_W]);
    end

    always_comb begin
        is_max = 1'b1;
        is_min = 1'b1;
        for (int i = 0; i < 27; i++) begin
            if (i != CTR) begin
                if (v[i] >= v[CTR]) is_max = 1'b0;
                if (v[i] <= v[CTR]) is_min = 1'b0;
            end
        end
        kind = is_max ? EXT_MAX : (is_min ? EXT_MIN : EXT_NONE);
    end

    always_comb begin
        abs_v       = v[CTR][DOG_W-1] ? DOG_W'(-v[CTR]) : DOG_W'(v[CTR]);
        contrast_ok = abs_v >= TH;
        shifted     = abs_v >> MAG_SHIFT;
        mag         = clip_mag(32'(shifted));
    end

    // middle-scale window: v[9+r*3+c]
    always_comb begin
        dxx   = EW'(v[12]) + EW'(v[14]) - K2 * EW'(v[CTR]);
        dyy   = EW'(v[10]) + EW'(v[16]) - K2 * EW'(v[CTR]);
        hxy   = EW'(v[9]) + EW'(v[17]) - EW'(v[11]) - EW'(v[15]);
        tr    = dxx + dyy;
        det16 = K16 * dxx * dyy - hxy * hxy;
        lhs   = K16 * tr * tr * KR;
        rhs   = KR1 * det16;
        edge_ok = (det16 > 0) && (lhs < rhs);
    end

    assign keep = (kind != EXT_NONE) && contrast_ok && edge_ok;

endmodule

// File: rtl/kp_detect.sv
module kp_detect
    import kp_pkg::*;
#(
    parameter int IMG_W        = 320,
    parameter int IMG_H        = 240,
    parameter int DOG_W        = 12,
    parameter int CONTRAST_MIN = 8,
    parameter int EDGE_RATIO   = 10,
    parameter int MAG_SHIFT    = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [DOG_W-1:0] in_dog_lo,
    input  logic signed [DOG_W-1:0] in_dog_mid,
    input  logic signed [DOG_W-1:0] in_dog_hi,
    input  logic [2:0]              in_scale,
    input  logic                    fifo_full,
    output logic                    fifo_wr_en,
    output logic [23:0]             fifo_wr_data,
    output logic                    overflow
);
    localparam logic [X_BITS-1:0] X_LAST = X_BITS'(IMG_W - 1);
    localparam logic [Y_BITS-1:0] Y_LAST = Y_BITS'(IMG_H - 1);

    logic signed [DOG_W-1:0] dog_in [3];
    logic [27*DOG_W-1:0]     cube;
    logic [X_BITS-1:0]       x_cnt;
    logic [Y_BITS-1:0]       y_cnt;

    logic                    s1_valid, s1_inner;
    kp_rec_t                 s1_rec;
    logic                    keep;
    logic [MAG_BITS-1:0]     mag;
    logic                    cand_v;
    kp_rec_t                 cand_rec;

    assign dog_in[0] = in_dog_lo;
    assign dog_in[1] = in_dog_mid;
    assign dog_in[2] = in_dog_hi;

    for (genvar s = 0; s < 3; s++) begin : g_scale
        kp_scale_window #(.IMG_W(IMG_W), .DOG_W(DOG_W)) i_win (
            .clk      (clk),
            .en       (in_valid),
            .din      (dog_in[s]),
            .win_flat (cube[s*9*DOG_W +: 9*DOG_W])
        );
    end

    // raster position of the incoming sample
    always_ff @(posedge clk) begin
        if (rst) begin
            x_cnt <= '0;
            y_cnt <= '0;
        end else if (in_valid) begin
            if (x_cnt == X_LAST) begin
                x_cnt <= '0;
                y_cnt <= (y_cnt == Y_LAST) ? '0 : y_cnt + 1'b1;
            end else begin
                x_cnt <= x_cnt + 1'b1;
            end
        end
    end

    // stage 1: window loaded, centre position tagged
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_inner <= 1'b0;
            s1_rec   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_inner     <= (x_cnt >= X_BITS'(2)) && (y_cnt >= Y_BITS'(2));
                s1_rec.x     <= x_cnt - 1'b1;
                s1_rec.y     <= y_cnt - 1'b1;
                s1_rec.scale <= in_scale;
                s1_rec.mag   <= '0;
            end
        end
    end

    kp_screen #(
        .DOG_W        (DOG_W),
        .CONTRAST_MIN (CONTRAST_MIN),
        .EDGE_RATIO   (EDGE_RATIO),
        .MAG_SHIFT    (MAG_SHIFT)
    ) i_screen (
        .cube (cube),
        .keep (keep),
        .mag  (mag)
    );

    // stage 2: candidate record offered to the FIFO
    always_ff @(posedge clk) begin
        if (rst) begin
            cand_v   <= 1'b0;
            cand_rec <= '0;
            overflow <= 1'b0;
        end else begin
            cand_v <= s1_valid && s1_inner && keep;
            if (s1_valid) begin
                cand_rec     <= s1_rec;
                cand_rec.mag <= mag;
            end
            if (cand_v && fifo_full) overflow <= 1'b1;
        end
    end

    assign fifo_wr_en   = cand_v && !fifo_full;
    assign fifo_wr_data = cand_rec;

endmodule

// File: rtl/kp_detect_chk.sv
module kp_detect_chk #(
    parameter int IMG_W = 320,
    parameter int IMG_H = 240
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [2:0]  in_scale,
    input logic        fifo_full,
    input logic        fifo_wr_en,
    input logic [19:0] rec_hi,
    input logic        overflow
);
    logic [8:0] rx;
    logic [7:0] ry;
    logic       rst_q;

    assign rx = rec_hi[19:11];
    assign ry = rec_hi[10:3];

    always_ff @(posedge clk) rst_q <= rst;

    assert_border_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_en |-> (rx >= 9'd1 && 32'(rx) <= IMG_W - 2 && ry >= 8'd1 && 32'(ry) <= IMG_H - 2));

    assert_scale_field_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_en |-> (rec_hi[2:0] == $past(in_scale, 2)));

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_en |-> $past(in_valid, 2));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_drop_when_full_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(fifo_full));

    always @(posedge clk) begin
        if (rst_q) begin
            assert_reset_R10: assert (!fifo_wr_en && !overflow);
        end
    end

endmodule

bind kp_detect kp_detect_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_scale   (in_scale),
    .fifo_full  (fifo_full),
    .fifo_wr_en (fifo_wr_en),
    .rec_hi     (fifo_wr_data[23:4]),
    .overflow   (overflow)
);

// File: tb/test_kp_detect.sv
`timescale 1ns/1ps
module test_kp_detect;

    localparam int W = 8;
    localparam int H = 6;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [11:0] d_lo = '0, d_mid = '0, d_hi = '0;
    logic [2:0]         in_scale = '0;
    logic               fifo_full = 1'b0;
    logic               fifo_wr_en;
    logic [23:0]        fifo_wr_data;
    logic               overflow;

    always #2.5 clk = ~clk;

    kp_detect #(
        .IMG_W(W), .IMG_H(H), .DOG_W(12),
        .CONTRAST_MIN(8), .EDGE_RATIO(10), .MAG_SHIFT(7)
    ) i_kp_detect (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_dog_lo(d_lo), .in_dog_mid(d_mid), .in_dog_hi(d_hi),
        .in_scale(in_scale), .fifo_full(fifo_full),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data), .overflow(overflow)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // frame description
    logic [2:0]         g_mask;
    int                 g_x, g_y;
    logic signed [11:0] g_v;
    bit                 g_line;
    // frame results
    int                 g_nwr, g_steps, g_tdrv, g_lat;
    logic [23:0]        g_word;

    typedef struct packed {
        logic [2:0]         mask;
        logic [3:0]         px;
        logic [3:0]         py;
        logic signed [11:0] val;
        logic               gap;
        logic [2:0]         sel;
        logic [1:0]         nexp;
        logic [3:0]         req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{3'b010, 4'd3, 4'd2, 12'sd300,   1'b0, 3'd5, 2'd1, 4'd2},  // R2 maximum
        '{3'b010, 4'd4, 4'd3, -12'sd2048, 1'b0, 3'd2, 2'd1, 4'd3},  // R3 minimum, R8 saturated magnitude
        '{3'b010, 4'd3, 4'd2, 12'sd7,     1'b0, 3'd1, 2'd0, 4'd5},  // R5 below threshold
        '{3'b010, 4'd3, 4'd2, 12'sd8,     1'b0, 3'd1, 2'd1, 4'd5},  // R5 at threshold
        '{3'b010, 4'd0, 4'd2, 12'sd300,   1'b0, 3'd0, 2'd0, 4'd7},  // R7 left column
        '{3'b010, 4'd7, 4'd4, 12'sd300,   1'b0, 3'd0, 2'd0, 4'd7},  // R7 right column
        '{3'b010, 4'd3, 4'd5, 12'sd300,   1'b0, 3'd0, 2'd0, 4'd7},  // R7 bottom row
        '{3'b001, 4'd3, 4'd2, 12'sd300,   1'b0, 3'd0, 2'd0, 4'd2},  // R2 spike only in lower scale
        '{3'b110, 4'd3, 4'd2, 12'sd300,   1'b0, 3'd0, 2'd0, 4'd4},  // R4 tie with upper scale
        '{3'b010, 4'd5, 4'd1, 12'sd500,   1'b1, 3'd7, 2'd1, 4'd11}, // R11 idle gaps
        '{3'b010, 4'd6, 4'd4, 12'sd1000,  1'b1, 3'd3, 2'd1, 4'd11}  // R11 idle gaps, R8 fields
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic signed [11:0] pix(int s, int xx, int yy);
        if (g_line && s == 1 && xx == g_x) return (yy == g_y) ? g_v : g_v - 12'sd1;
        if (!g_line && g_mask[s] && xx == g_x && yy == g_y) return g_v;
        return 12'sd0;
    endfunction

    function automatic logic [23:0] exp_word(int xx, int yy, logic [2:0] sel, logic signed [11:0] v);
        int a = (v < 0) ? -int'(v) : int'(v);
        int m = a / 128;
        if (m > 15) m = 15;
        return {9'(xx), 8'(yy), sel, 4'(m)};
    endfunction

    task automatic observe();
        if (fifo_wr_en) begin
            g_nwr++;
            g_word = fifo_wr_data;
            g_lat  = g_steps - g_tdrv;
        end
    endtask

    task automatic run_frame(input bit gap, input logic [2:0] sel);
        g_nwr = 0; g_steps = 0; g_tdrv = -100; g_lat = -1; g_word = '0;
        for (int yy = 0; yy < H; yy++) begin
            for (int xx = 0; xx < W; xx++) begin
                @(negedge clk);
                observe();
                in_valid = 1'b1;
                in_scale = sel;
                d_lo  = pix(0, xx, yy);
                d_mid = pix(1, xx, yy);
                d_hi  = pix(2, xx, yy);
                if (xx == g_x + 1 && yy == g_y + 1) g_tdrv = g_steps;
                g_steps++;
                if (gap) begin
                    @(negedge clk);
                    observe();
                    in_valid = 1'b0;
                    in_scale = ~sel;
                    d_mid = 12'sd1500;
                    g_steps++;
                end
            end
        end
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            observe();
            in_valid = 1'b0;
            d_lo = '0; d_mid = '0; d_hi = '0;
            g_steps++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!fifo_wr_en, "R10 wr_en after reset", 32'(fifo_wr_en), 0);
        check(!overflow,   "R10 overflow after reset", 32'(overflow), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            g_mask = TBL[i].mask; g_x = int'(TBL[i].px); g_y = int'(TBL[i].py);
            g_v = TBL[i].val; g_line = 0;
            run_frame(TBL[i].gap, TBL[i].sel);
            check(g_nwr == int'(TBL[i].nexp), $sformatf("R%0d record count, vector %0d", TBL[i].req, i),
                  32'(g_nwr), 32'(TBL[i].nexp));
            if (TBL[i].nexp == 2'd1)
                check(g_word == exp_word(g_x, g_y, TBL[i].sel, g_v),
                      $sformatf("R8 record word, vector %0d", i),
                      32'(g_word), 32'(exp_word(g_x, g_y, TBL[i].sel, g_v)));
        end

        // R1: record offered two clocks after the completing sample
        g_mask = 3'b010; g_x = 2; g_y = 3; g_v = 12'sd400; g_line = 0;
        run_frame(1'b0, 3'd4);
        check(g_nwr == 1, "R1 record count", 32'(g_nwr), 1);
        check(g_lat == 2, "R1 latency", 32'(g_lat), 2);

        // R6: ridge along a column is rejected as an edge
        g_x = 3; g_y = 2; g_v = 12'sd100; g_line = 1;
        run_frame(1'b0, 3'd6);
        check(g_nwr == 0, "R6 ridge rejected", 32'(g_nwr), 0);

        // R9: full FIFO drops the record and sets overflow
        g_line = 0; g_mask = 3'b010; g_x = 3; g_y = 2; g_v = 12'sd300;
        fifo_full = 1'b1;
        run_frame(1'b0, 3'd5);
        check(g_nwr == 0, "R9 no write while full", 32'(g_nwr), 0);
        check(overflow,   "R9 overflow set", 32'(overflow), 1);
        fifo_full = 1'b0;
        run_frame(1'b0, 3'd5);
        check(g_nwr == 1, "R9 write resumes", 32'(g_nwr), 1);
        check(overflow,   "R9 overflow sticky", 32'(overflow), 1);

        // R10: reset clears overflow
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check(!overflow,   "R10 overflow cleared", 32'(overflow), 0);
        check(!fifo_wr_en, "R10 no write in reset", 32'(fifo_wr_en), 0);
        rst = 1'b0;

        // R10: position restarts at (0,0) after reset
        g_mask = 3'b010; g_x = 1; g_y = 1; g_v = -12'sd200; g_line = 0;
        run_frame(1'b0, 3'd2);
        check(g_nwr == 1, "R10 count after reset", 32'(g_nwr), 1);
        check(g_word == exp_word(1, 1, 3'd2, g_v), "R10 position after reset",
              32'(g_word), 32'(exp_word(1, 1, 3'd2, g_v)));

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule